// File: doc/BRIEF.md
# Raster Timing Generator with Beam Status Word

This block derives the horizontal and vertical timing of a low-resolution raster display from a single pixel-clock enable. The pixel clock is the 27 MHz master clock divided by four. A line is 432 pixel clocks long and shows 320 of them. A frame is 262 lines long and shows 240 of them. From two free-running counters the block produces hsync, vsync and a blanking flag. It also raises a vertical-blank interrupt request once per frame. That request goes to two processors on two identical outputs, and it stays raised until a clear pulse arrives.

Software polls the beam through a read-only 16-bit status word. On a read strobe the block latches the sync and blank flags, active low, inside an upper byte that otherwise reads all ones. In the low byte it latches an offset line number: the current line plus 15, wrapped modulo the frame length. When that offset line is 256 or more, the low byte reads 0xFF.

Top module: `raster_timing`

## Requirements
- R1: After reset h_pos and v_pos are 0, hsync, vsync, blank, irq_a and irq_b are 0, and status is 0x0000.
- R2: On a clock with pix_en high, h_pos advances by one and wraps from 431 to 0. On that wrap v_pos advances by one and wraps from 261 to 0. With pix_en low, both counters hold.
- R3: hsync is 1 exactly while h_pos is in 352..383.
- R4: vsync is 1 exactly while v_pos is in 250..252.
- R5: blank is 1 exactly while h_pos >= 320 or v_pos >= 240.
- R6: irq_a and irq_b are always equal. They become 1 on the clock edge that moves the beam from (h 431, line 239) to (h 0, line 240). They return to 0 only on a clock with irq_clr high. When the setting edge and irq_clr coincide, the request is set. irq_clr has no effect while the request is already 0.
- R7: On a clock with rd_stb high, status captures the beam state present before that edge. Otherwise status holds. The upper byte is laid out as follows: bit 15 = NOT hsync, bit 14 = NOT vsync, bits 13..9 = 1, bit 8 = NOT blank. With no flag active the upper byte therefore reads 0xFF.
- R8: The status low byte is (v_pos + 15) mod 262 when that value is below 256, and 0xFF otherwise. For example, lines 241..246 give 0xFF, line 247 gives 0x00 and line 261 gives 0x0E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel-clock enable, one pixel per high cycle |
| irq_clr | input | 1 | Pulse that drops the vertical interrupt request |
| rd_stb | input | 1 | Latches the status word |
| h_pos | output | 9 | Pixel position within the line |
| v_pos | output | 9 | Line number within the frame |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| blank | output | 1 | Outside the visible area |
| irq_a | output | 1 | Vertical-blank request to the first processor |
| irq_b | output | 1 | Vertical-blank request to the second processor |
| status | output | 16 | Latched beam status word |

## Verification
The counters, the request and the status word are registers, so each of them changes on the edge that follows the cycle in which its cause is presented. The sync and blank flags are decoded from the counters without a register, so they are valid in the same cycle as the counter values. The bench drives its inputs on the falling edge and keeps a model of the beam that it advances by one pixel for each rising edge with pix_en high. It compares every output against that model at the next falling edge, so each registered result is sampled one edge after its cause. The expected status value comes from the model position before the edge, because the strobe captures the pre-edge state.

// File: rtl/raster_timing.sv
module raster_timing #(
  parameter int H_TOTAL  = 432,
  parameter int H_VIS    = 320,
  parameter int HS_START = 352,
  parameter int HS_END   = 384,
  parameter int V_TOTAL  = 262,
  parameter int V_VIS    = 240,
  parameter int VS_START = 250,
  parameter int VS_END   = 253,
  parameter int LINE_OFS = 15,
  parameter int HW = $clog2(H_TOTAL),
  parameter int VW = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          irq_clr,
  input  logic          rd_stb,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos,
  output logic          hsync,
  output logic          vsync,
  output logic          blank,
  output logic          irq_a,
  output logic          irq_b,
  output logic [15:0]   status
);
  logic          line_end, frame_end, vbl_start, irq_q;
  logic [VW:0]   v_ofs, v_wrap;
  logic [7:0]    line_byte;

  assign line_end  = (h_pos == HW'(H_TOTAL - 1));
  assign frame_end = (v_pos == VW'(V_TOTAL - 1));
  assign vbl_start = pix_en && line_end && (v_pos == VW'(V_VIS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_pos <= '0;
      v_pos <= '0;
    end else if (pix_en) begin
      h_pos <= line_end ? '0 : h_pos + 1'b1;
      if (line_end) v_pos <= frame_end ? '0 : v_pos + 1'b1;
    end
  end

  assign hsync = (h_pos >= HW'(HS_START)) && (h_pos < HW'(HS_END));
  assign vsync = (v_pos >= VW'(VS_START)) && (v_pos < VW'(VS_END));
  assign blank = (h_pos >= HW'(H_VIS)) || (v_pos >= VW'(V_VIS));

  always_ff @(posedge clk) begin
    if (!rst_n)         irq_q <= 1'b0;
    else if (vbl_start) irq_q <= 1'b1;
    else if (irq_clr)   irq_q <= 1'b0;
  end

  assign irq_a = irq_q;
  assign irq_b = irq_q;

  assign v_ofs     = {1'b0, v_pos} + (VW+1)'(LINE_OFS);
  assign v_wrap    = (v_ofs >= (VW+1)'(V_TOTAL)) ? v_ofs - (VW+1)'(V_TOTAL) : v_ofs;
  assign line_byte = (v_wrap < (VW+1)'(256)) ? v_wrap[7:0] : 8'hFF;

  always_ff @(posedge clk) begin
    if (!rst_n)      status <= '0;
    else if (rd_stb) status <= {~hsync, ~vsync, 5'h1F, ~blank, line_byte};
  end
endmodule

module raster_timing_chk #(
  parameter int H_TOTAL = 432,
  parameter int H_VIS   = 320,
  parameter int V_TOTAL = 262,
  parameter int V_VIS   = 240,
  parameter int HW = $clog2(H_TOTAL),
  parameter int VW = $clog2(V_TOTAL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          rd_stb,
  input logic [HW-1:0] h_pos,
  input logic [VW-1:0] v_pos,
  input logic          hsync,
  input logic          vsync,
  input logic          blank,
  input logic          irq_a,
  input logic          irq_b,
  input logic [15:0]   status
);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(h_pos) && $stable(v_pos)));
  // R2
  range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (h_pos < HW'(H_TOTAL)) && (v_pos < VW'(V_TOTAL)));
  // R3
  hs_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> blank);
  // R4
  vs_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> blank);
  // R6
  irq_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_a == irq_b);
  // R6
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_a) |-> (v_pos == VW'(V_VIS) && h_pos == '0));
  // R7
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(status));
endmodule

bind raster_timing raster_timing_chk #(
  .H_TOTAL(H_TOTAL), .H_VIS(H_VIS), .V_TOTAL(V_TOTAL), .V_VIS(V_VIS)
) chk_i (
  .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .rd_stb(rd_stb),
  .h_pos(h_pos), .v_pos(v_pos), .hsync(hsync), .vsync(vsync),
  .blank(blank), .irq_a(irq_a), .irq_b(irq_b), .status(status)
);

// File: tb/raster_timing_tb.sv
module raster_timing_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pix_en = 1'b0, irq_clr = 1'b0, rd_stb = 1'b0;
  logic [8:0] h_pos, v_pos;
  logic       hsync, vsync, blank, irq_a, irq_b;
  logic [15:0] status;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  int mh = 0, mv = 0, frames = 0;
  bit mirq = 1'b0;
  logic [15:0] mstat = 16'h0000;

  always #4 clk = ~clk;

  raster_timing dut_i (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .irq_clr(irq_clr), .rd_stb(rd_stb),
    .h_pos(h_pos), .v_pos(v_pos), .hsync(hsync), .vsync(vsync), .blank(blank),
    .irq_a(irq_a), .irq_b(irq_b), .status(status)
  );

  function automatic bit f_hs(int h); return (h >= 352) && (h <= 383); endfunction
  function automatic bit f_vs(int v); return (v >= 250) && (v <= 252); endfunction
  function automatic bit f_bl(int h, int v); return (h >= 320) || (v >= 240); endfunction
  function automatic logic [15:0] f_stat(int h, int v);
    int o;
    logic [7:0] lo;
    o  = (v + 15) % 262;
    lo = (o < 256) ? 8'(o) : 8'hFF;
    return {~f_hs(h), ~f_vs(v), 5'h1F, ~f_bl(h, v), lo};
  endfunction

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (h=%0d v=%0d)", req, act, exp, mh, mv);
    end
  endtask

  task automatic check_all();
    chk("R2 h_pos", h_pos, mh);
    chk("R2 v_pos", v_pos, mv);
    chk("R3 hsync", hsync, f_hs(mh));
    chk("R4 vsync", vsync, f_vs(mv));
    chk("R5 blank", blank, f_bl(mh, mv));
    chk("R6 irq_a", irq_a, mirq);
    chk("R6 irq_b", irq_b, mirq);
    chk("R7 R8 status", status, mstat);
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk("R1 h_pos", h_pos, 0);
    chk("R1 v_pos", v_pos, 0);
    chk("R1 irq", {irq_a, irq_b}, 0);
    chk("R1 flags", {hsync, vsync, blank}, 0);
    chk("R1 status", status, 0);
    rst_n = 1'b1;
    while (!(frames == 1 && mv == 20)) begin
      check_all();
      pix_en  = ($urandom % 8) != 0;
      rd_stb  = ($urandom % 16) == 0;
      irq_clr = 1'b0;
      if (mh == 431 && mv == 239) begin
        pix_en = 1'b1; irq_clr = 1'b1;
      end
      if (mh == 0 && (mv == 100 || mv == 245)) irq_clr = 1'b1;
      if (mv >= 239 && mv <= 250 && mh == 5) rd_stb = 1'b1;
      if ((mv == 261 || mv == 0) && mh == 7) rd_stb = 1'b1;
      if (rd_stb) mstat = f_stat(mh, mv);
      if (pix_en && mh == 431 && mv == 239) mirq = 1'b1;
      else if (irq_clr) mirq = 1'b0;
      if (pix_en) begin
        if (mh == 431) begin
          mh = 0;
          if (mv == 261) begin mv = 0; frames++; end
          else mv++;
        end else mh++;
      end
      @(negedge clk);
    end
    check_all();
    chk("R8 wrap line 261", f_stat(0, 261) & 16'h00FF, 16'h000E);
    chk("R8 saturate line 246", f_stat(0, 246) & 16'h00FF, 16'h00FF);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule